// File: doc/BRIEF.md
# Serial Command Decoder with Protected Status Register

This block is a serial-peripheral slave for clock modes 0 and 3. It takes 8-bit opcodes most significant bit first on the data input and keeps an 8-bit status register. That register holds the settings a supervisor needs: a lock-enable bit, a software flag, a two-bit watchdog period select, a two-bit block-protect select, a write-enable latch and a busy indication. A write to the register is nonvolatile, so a self-timed busy counter models its duration. The memory array beside this block reads the write-enable latch and the busy indication from its ports.

The SPI pins are sampled by the system clock, which must be several times faster than the serial clock. A command takes effect only when chip select rises at exactly the right bit count. A status write is also refused while an external guard pin is low and the lock-enable bit is set. The serial output is driven through an enable, which is low whenever chip select is high.

Top module: `sdec_top`

## Requirements
- R1: After reset every status bit reads 0, `wel_o` and `busy_o` are 0 and `miso_oe` is 0.
- R2: Opcode 0x06 sets the write-enable latch (status bit 1). It does so only when chip select rises after exactly 8 bits. A frame of 7 or 9 bits leaves the status unchanged.
- R3: With exactly 8 bits, opcode 0x00 sets the flag (status bit 6), and opcode 0x04 clears both the flag and the write-enable latch.
- R4: After opcode 0x05, the status is shifted out most significant bit first. The layout is: bit 7 lock-enable, bit 6 flag, bits 5:4 watchdog select, bits 3:2 block select, bit 1 write-enable latch, bit 0 busy. The output changes only after a falling serial clock edge, and the byte repeats every 8 further bits.
- R5: `miso_oe` is 1 while chip select is low and 0 while it is high.
- R6: Opcode 0x01 followed by one data byte writes data bits 7:2 into status bits 7:2. It does so only when chip select rises after exactly 16 bits with the write-enable latch set. Data bits 1:0 are discarded. `wdog_sel` and `blk_sel` follow status bits 5:4 and 3:2.
- R7: A status write is refused while `guard_n` is 0 and the lock-enable bit is 1. With `guard_n` at 1, or with lock-enable at 0, the write goes ahead.
- R8: An accepted status write holds busy at 1 for exactly BUSY_CYCLES clock cycles. The write-enable latch clears when busy ends.
- R9: While busy is 1, every opcode other than 0x05 has no effect.
- R10: Opcode 0x05 works while busy is 1 and reports bit 0 as 1.
- R11: Opcodes 0x03, 0x02 and unassigned codes leave the status unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| sck | input | 1 | Serial clock |
| cs_n | input | 1 | Active-low chip select |
| mosi | input | 1 | Serial data in |
| guard_n | input | 1 | Low engages the status lock when lock-enable is set |
| miso | output | 1 | Serial data out |
| miso_oe | output | 1 | Output enable for miso |
| wel_o | output | 1 | Write-enable latch to the array |
| busy_o | output | 1 | Self-timed write in progress |
| wdog_sel | output | 2 | Watchdog period select |
| blk_sel | output | 2 | Block protect select |

## Verification
The assertions check several rules on every cycle. The serial output moves only after a falling serial clock edge. The output enable is off while chip select is high. The protected fields stay fixed during busy and change only when no lock was active. The latch clears when busy falls and never rises while busy. The bench scenarios are the only way to show the bit-count rules for acceptance, the exact status values after each opcode in both clock modes, the repeated status byte, and the measured busy length.

// File: rtl/sdec_pkg.sv
package sdec_pkg;
    localparam logic [7:0] OP_SET_WEL = 8'h06;
    localparam logic [7:0] OP_SET_FLG = 8'h00;
    localparam logic [7:0] OP_CLR_WEL = 8'h04;
    localparam logic [7:0] OP_RD_STAT = 8'h05;
    localparam logic [7:0] OP_WR_STAT = 8'h01;

    typedef struct packed {
        logic       lock_en;
        logic       flag;
        logic [1:0] wd;
        logic [1:0] bl;
        logic       wel;
    } stat_t;
endpackage

// File: rtl/sdec_spi_rx.sv
module sdec_spi_rx #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sck,
    input  logic             cs_n,
    input  logic             mosi,
    output logic             sck_rise,
    output logic             sck_fall,
    output logic             cs_rise,
    output logic [CNT_W-1:0] cnt,
    output logic [7:0]       rx_next
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic             sck;
        logic             csn;
        logic [CNT_W-1:0] cnt;
        logic [7:0]       rx;
    } rx_t;

    rx_t d, q;

    always_comb begin
        sck_rise = sck & ~q.sck & ~cs_n;
        sck_fall = ~sck & q.sck & ~cs_n;
        cs_rise  = cs_n & ~q.csn;
        rx_next  = {q.rx[6:0], mosi};
        cnt      = q.cnt;
        d        = q;
        d.sck    = sck;
        d.csn    = cs_n;
        if (cs_n) begin
            d.cnt = '0;
        end else if (sck_rise) begin
            d.rx = rx_next;
            if (q.cnt != CNT_MAX) d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{sck: 1'b0, csn: 1'b1, cnt: '0, rx: '0};
        end else begin
            q <= d;
        end
    end

    // R2: the bit count moves only on a rising serial clock inside a frame
    p_cnt_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !$past(cs_n) && !$past(sck_rise)) |-> $stable(cnt));
endmodule

// File: rtl/sdec_busy.sv
module sdec_busy #(
    parameter int CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int BW = $clog2(CYCLES + 1);

    logic [BW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start && cnt_q == '0) cnt_d = BW'(CYCLES);
        else if (cnt_q != '0)     cnt_d = cnt_q - 1'b1;
        busy = (cnt_q != '0);
        done = (cnt_q == BW'(1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R8: the count never exceeds the configured length
    p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= BW'(CYCLES));
    // R9: a new write is never launched while one runs
    p_start_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);
endmodule

// File: rtl/sdec_top.sv
module sdec_top #(
    parameter int BUSY_CYCLES = 1000,
    parameter int CNT_W       = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sck,
    input  logic       cs_n,
    input  logic       mosi,
    input  logic       guard_n,
    output logic       miso,
    output logic       miso_oe,
    output logic       wel_o,
    output logic       busy_o,
    output logic [1:0] wdog_sel,
    output logic [1:0] blk_sel
);
    import sdec_pkg::*;

    localparam logic [CNT_W-1:0] CNT_OP   = CNT_W'(8);
    localparam logic [CNT_W-1:0] CNT_DATA = CNT_W'(16);

    typedef struct packed {
        stat_t      st;
        logic [7:0] op;
        logic [7:0] dat;
        logic [7:0] tx;
        logic       oe;
    } top_t;

    top_t d, q;

    logic             sck_rise, sck_fall, cs_rise;
    logic [CNT_W-1:0] cnt;
    logic [7:0]       rx_next;
    logic             start, busy, done, locked;
    logic [7:0]       status_now;

    sdec_spi_rx #(.CNT_W(CNT_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .mosi(mosi),
        .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_rise(cs_rise),
        .cnt(cnt), .rx_next(rx_next)
    );

    sdec_busy #(.CYCLES(BUSY_CYCLES)) u_busy (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done)
    );

    always_comb begin
        d          = q;
        start      = 1'b0;
        status_now = {q.st, busy};
        locked     = ~guard_n & q.st.lock_en;
        d.oe       = ~cs_n;

        if (sck_rise) begin
            if (cnt == CNT_W'(7))  d.op  = rx_next;
            if (cnt == CNT_W'(15)) d.dat = rx_next;
        end

        if (sck_fall && cnt >= CNT_OP && q.op == OP_RD_STAT) begin
            if (cnt[2:0] == 3'd0) d.tx = status_now;
            else                  d.tx = {q.tx[6:0], 1'b0};
        end

        if (cs_rise && !busy) begin
            if (cnt == CNT_OP) begin
                unique case (q.op)
                    OP_SET_WEL: d.st.wel = 1'b1;
                    OP_SET_FLG: d.st.flag = 1'b1;
                    OP_CLR_WEL: begin
                        d.st.wel  = 1'b0;
                        d.st.flag = 1'b0;
                    end
                    default: ;
                endcase
            end else if (cnt == CNT_DATA && q.op == OP_WR_STAT && q.st.wel && !locked) begin
                d.st.lock_en = q.dat[7];
                d.st.flag    = q.dat[6];
                d.st.wd      = q.dat[5:4];
                d.st.bl      = q.dat[3:2];
                start        = 1'b1;
            end
        end

        if (done) d.st.wel = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign miso     = q.tx[7];
    assign miso_oe  = q.oe;
    assign wel_o    = q.st.wel;
    assign busy_o   = busy;
    assign wdog_sel = q.st.wd;
    assign blk_sel  = q.st.bl;

    // R4: serial output moves only after a falling serial clock
    p_miso_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(miso) |-> $past(sck_fall));
    // R5: no drive while deselected
    p_oe_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cs_n) |-> !miso_oe);
    // R7: protected fields change only when no lock was active
    p_nv_lock_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({q.st.lock_en, q.st.wd, q.st.bl}) |-> $past(!locked));
    // R9: protected fields are frozen during busy
    p_nv_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable({q.st.lock_en, q.st.wd, q.st.bl}));
    // R8: latch is clear once busy ends
    p_wel_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> !wel_o);
    // R9: latch never rises from a command issued during busy
    p_wel_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wel_o) |-> $past(!busy));
endmodule

// File: tb/tb_sdec_top.sv
`timescale 1ns/1ps
module tb_sdec_top;
    localparam int BUSY = 600;
    localparam int NV   = 23;

    typedef struct packed {
        logic [3:0]  rq;
        logic        g;
        logic        m3;
        logic [4:0]  nb;
        logic [23:0] bits;
        logic [7:0]  exp;
    } vec_t;

    localparam vec_t VEC [NV] = '{
        '{4'd2,  1'b1, 1'b0, 5'd8,  24'h060000, 8'h02},
        '{4'd3,  1'b1, 1'b1, 5'd8,  24'h040000, 8'h00},
        '{4'd2,  1'b1, 1'b0, 5'd9,  24'h060000, 8'h00},
        '{4'd3,  1'b1, 1'b1, 5'd8,  24'h000000, 8'h40},
        '{4'd2,  1'b1, 1'b0, 5'd7,  24'h060000, 8'h40},
        '{4'd2,  1'b1, 1'b1, 5'd8,  24'h060000, 8'h42},
        '{4'd6,  1'b1, 1'b0, 5'd16, 24'h01FF00, 8'hFC},
        '{4'd3,  1'b1, 1'b1, 5'd8,  24'h040000, 8'hBC},
        '{4'd2,  1'b1, 1'b0, 5'd8,  24'h060000, 8'hBE},
        '{4'd7,  1'b0, 1'b1, 5'd16, 24'h010000, 8'hBE},
        '{4'd7,  1'b1, 1'b0, 5'd16, 24'h010000, 8'h00},
        '{4'd2,  1'b1, 1'b1, 5'd8,  24'h060000, 8'h02},
        '{4'd6,  1'b1, 1'b0, 5'd17, 24'h013000, 8'h02},
        '{4'd6,  1'b1, 1'b1, 5'd16, 24'h013300, 8'h30},
        '{4'd6,  1'b1, 1'b0, 5'd16, 24'h010C00, 8'h30},
        '{4'd11, 1'b1, 1'b1, 5'd8,  24'h030000, 8'h30},
        '{4'd2,  1'b1, 1'b0, 5'd8,  24'h060000, 8'h32},
        '{4'd11, 1'b1, 1'b1, 5'd24, 24'h020000, 8'h32},
        '{4'd7,  1'b0, 1'b0, 5'd16, 24'h018000, 8'h80},
        '{4'd2,  1'b0, 1'b1, 5'd8,  24'h060000, 8'h82},
        '{4'd7,  1'b0, 1'b0, 5'd16, 24'h010000, 8'h82},
        '{4'd7,  1'b1, 1'b1, 5'd16, 24'h010000, 8'h00},
        '{4'd11, 1'b1, 1'b0, 5'd8,  24'hA50000, 8'h00}
    };

    logic clk = 1'b0, rst_n = 1'b0, sck = 1'b0, cs_n = 1'b1, mosi = 1'b0, guard_n = 1'b1;
    logic miso, miso_oe, wel_o, busy_o;
    logic [1:0] wdog_sel, blk_sel;
    int checks = 0, errors = 0, busy_hi = 0;

    always #2.5 clk = ~clk;
    always @(negedge clk) if (busy_o) busy_hi++;

    sdec_top #(.BUSY_CYCLES(BUSY), .CNT_W(8)) dut (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .mosi(mosi),
        .guard_n(guard_n), .miso(miso), .miso_oe(miso_oe), .wel_o(wel_o),
        .busy_o(busy_o), .wdog_sel(wdog_sel), .blk_sel(blk_sel)
    );

    function automatic string tag(input logic [3:0] rq);
        case (rq)
            4'd2:    return "R2";
            4'd3:    return "R3";
            4'd6:    return "R6";
            4'd7:    return "R7";
            default: return "R11";
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic xfer(input logic [23:0] bits, input int nb, input logic m3,
                        output logic [23:0] got);
        got = '0;
        @(negedge clk); sck = m3;
        repeat (2) @(negedge clk);
        cs_n = 1'b0;
        repeat (4) @(negedge clk);
        for (int i = 0; i < nb; i++) begin
            sck  = 1'b0;
            mosi = bits[23-i];
            repeat (4) @(negedge clk);
            got = {got[22:0], miso};
            sck = 1'b1;
            repeat (4) @(negedge clk);
        end
        if (!m3) begin
            sck = 1'b0;
            repeat (4) @(negedge clk);
        end
        cs_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic rdsr(input logic m3, output logic [7:0] st);
        logic [23:0] g;
        xfer(24'h050000, 16, m3, g);
        st = g[7:0];
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [7:0]  st;
        logic [23:0] g;
        int          base;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1 reset state
        chk("R1 miso_oe", {31'd0, miso_oe}, 32'd0);
        chk("R1 wel/busy", {30'd0, wel_o, busy_o}, 32'd0);
        rdsr(1'b0, st);
        chk("R1 status", {24'd0, st}, 32'h00);

        // R5 output enable follows chip select
        cs_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R5 oe low-cs", {31'd0, miso_oe}, 32'd1);
        cs_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R5 oe high-cs", {31'd0, miso_oe}, 32'd0);

        // table walk
        for (int k = 0; k < NV; k++) begin
            guard_n = VEC[k].g;
            xfer(VEC[k].bits, int'(VEC[k].nb), VEC[k].m3, g);
            guard_n = 1'b1;
            repeat (BUSY + 50) @(negedge clk);
            rdsr(~VEC[k].m3, st);
            chk(tag(VEC[k].rq), {24'd0, st}, {24'd0, VEC[k].exp});
            chk("R6 ports", {26'd0, wdog_sel, blk_sel, wel_o, busy_o},
                {26'd0, VEC[k].exp[5:4], VEC[k].exp[3:2], VEC[k].exp[1], 1'b0});
        end

        // R4 status repeats every eight bits (status 0x02)
        xfer(24'h060000, 8, 1'b0, g);
        xfer(24'h050000, 24, 1'b1, g);
        chk("R4 first byte", {24'd0, g[15:8]}, 32'h02);
        chk("R4 repeat byte", {24'd0, g[7:0]}, 32'h02);

        // R8 R9 R10 busy window
        base = busy_hi;
        xfer(24'h011000, 16, 1'b0, g);
        chk("R8 busy port", {31'd0, busy_o}, 32'd1);
        rdsr(1'b1, st);
        chk("R10 read during busy", {24'd0, st}, 32'h13);
        xfer(24'h040000, 8, 1'b0, g);
        xfer(24'h000000, 8, 1'b1, g);
        rdsr(1'b0, st);
        chk("R9 ignored during busy", {24'd0, st}, 32'h13);
        for (int t = 0; t < 2000 && busy_o; t++) @(negedge clk);
        repeat (2) @(negedge clk);
        chk("R8 busy length", busy_hi - base, BUSY);
        rdsr(1'b0, st);
        chk("R8 latch cleared", {24'd0, st}, 32'h10);

        // R1 reset clears a non-zero state
        xfer(24'h060000, 8, 1'b0, g);
        xfer(24'h000000, 8, 1'b0, g);
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk); rst_n = 1'b1;
        repeat (3) @(negedge clk);
        rdsr(1'b1, st);
        chk("R1 status after reset", {24'd0, st}, 32'h00);

        finish_run();
    end
endmodule